// File: doc/BRIEF.md
# Serial Memory Slave Front End

This block sits between a four-wire serial bus and a 256-byte memory model. It oversamples the serial clock, chip select, hold and write-protect pins in the system clock domain. It takes in an 8-bit command code, then an 8-bit address where the command needs one, then data, all most significant bit first. It serves sequential reads from a synchronous array and passes the written bytes and a commit pulse to a separate commit block. That commit block reports back while it is busy.

Six commands are decoded: 0x06 sets the write-enable flag, 0x04 clears it, 0x05 returns the status byte, 0x01 loads the protection level, 0x03 reads and 0x02 writes. After a command is finished or refused, the slave ignores the bus until chip select goes high again. A hold pin can pause a transfer in the middle without losing its place.

Top module: `spi_mem_slave`

## Requirements
- R1: Input bits are taken on rising serial-clock edges and the output changes on falling edges, MSB first. The same transfer works whether the clock idles low or idles high.
- R2: After reset, no command is accepted until chip select has gone from high to low at least once.
- R3: The status byte is {4'b1111, level[1:0], wel, busy}, with wel in bit 1 and busy in bit 0. Command 0x06 sets wel and 0x04 clears it.
- R4: Command 0x05 shifts out the status byte once. After its eighth bit, miso_oe stays low until deselect.
- R5: Command 0x03 takes an address and then streams mem bytes from it. The address rises by one after each byte and wraps from 0xFF to 0x00.
- R6: A read or write command that arrives while busy is high is refused and the slave waits for deselect. No write byte is staged while busy is high.
- R7: With wel set, each completed write byte is staged on wr_stb. The address advances within its 16-byte page, so 0x3F is followed by 0x30. A deselect exactly on a byte boundary after at least one data byte pulses wr_go for one cycle and clears wel.
- R8: A write with wel clear, or one deselected in the middle of a byte, stages nothing and gives no wr_go. An aborted write leaves wel set.
- R9: Command 0x01 followed by one byte loads bits 3:2 of that byte as the protection level and clears wel. This happens only if wel is set and chip select rises before another clock rise. One extra clock rise cancels the load and leaves wel set.
- R10: Protection level 1 covers addresses 0xC0–0xFF, level 2 covers 0x80–0xFF and level 3 covers the whole array. A byte aimed at a protected address is not staged.
- R11: An unknown command code makes the slave ignore the rest of the transfer. A valid code that follows it in the same transfer has no effect.
- R12: A falling hold with the clock low pauses the transfer: miso_oe goes low and clock edges are ignored. A rising hold with the clock low resumes the transfer where it stopped.
- R13: While wpn is low, wel is held clear.
- R14: miso_oe is high only while read data or status bits are being shifted out to a selected master.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| sck | input | 1 | Serial clock, oversampled |
| csn | input | 1 | Chip select, active low |
| mosi | input | 1 | Serial data in |
| holdn | input | 1 | Pause request, active low |
| wpn | input | 1 | Write-protect pin, active low |
| wip | input | 1 | Commit block busy |
| mem_rdata | input | 8 | Array read data, one cycle after mem_addr |
| miso | output | 1 | Serial data out |
| miso_oe | output | 1 | Output drive enable; low stands for high impedance |
| mem_addr | output | 8 | Array read address |
| wr_stb | output | 1 | One staged write byte is valid |
| wr_addr | output | 8 | Address of the staged byte |
| wr_data | output | 8 | Staged byte |
| wr_go | output | 1 | Start pulse for the commit block |

## Verification
Two events can land on one system cycle: a chip-select rise and the serial-clock fall that the master gives just before it. The slave must treat that fall as an ordinary output edge and still judge the commit on the byte count. The bench provokes this by dropping the clock a few cycles before deselect after the final write or status byte. It then judges the result by the count of wr_go pulses, by the staged-byte queue that is compared against wr_stb on every clock, and by the status byte read back afterwards. The hold pause is also placed inside a read data byte, so that pausing and shifting meet on the same bit.

// File: rtl/spi_mem_slave.sv
module spi_mem_slave #(
  parameter int AW        = 8,
  parameter int PAGE_BITS = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sck,
  input  logic          csn,
  input  logic          mosi,
  input  logic          holdn,
  input  logic          wpn,
  input  logic          wip,
  input  logic [7:0]    mem_rdata,
  output logic          miso,
  output logic          miso_oe,
  output logic [AW-1:0] mem_addr,
  output logic          wr_stb,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  output logic          wr_go
);
  localparam logic [4:0] SYNC_RST = 5'b10100;

  typedef enum logic [3:0] {
    ST_IDLE, ST_OPC, ST_ADDR, ST_RD, ST_WR, ST_SRO, ST_SRI, ST_SRE, ST_WAIT
  } st_t;

  logic [4:0] m1, m2;
  logic p_sck, p_csn, p_hold;
  st_t st;
  logic [2:0] cnt, ocnt;
  logic [6:0] sh;
  logic [7:0] dsh;
  logic [AW-1:0] addr;
  logic [1:0] bp, sr_new;
  logic is_rd, got, wel, held, live;

  wire s_sck  = m2[0];
  wire s_csn  = m2[1];
  wire s_hold = m2[2];
  wire s_mosi = m2[3];
  wire s_wp   = m2[4];

  wire rise      = s_sck & ~p_sck;
  wire fall      = ~s_sck & p_sck;
  wire cs_fall   = p_csn & ~s_csn;
  wire cs_rise   = ~p_csn & s_csn;
  wire hold_fall = p_hold & ~s_hold;
  wire hold_rise = ~p_hold & s_hold;
  wire last      = (cnt == 3'd7);
  wire [7:0] byte_in = {sh, s_mosi};
  wire out_st    = (st == ST_RD) || (st == ST_SRO);
  wire in_st     = (st != ST_IDLE) && (st != ST_WAIT);

  function automatic logic prot(input logic [1:0] lvl, input logic [AW-1:0] a);
    return (lvl == 2'd3) || (lvl == 2'd2 && a[AW-1]) ||
           (lvl == 2'd1 && a[AW-1:AW-2] == 2'b11);
  endfunction

  assign mem_addr = addr;
  assign miso     = dsh[7];
  assign miso_oe  = ~s_csn & ~held & live & out_st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m1 <= SYNC_RST;
      m2 <= SYNC_RST;
      p_sck <= 1'b0;
      p_csn <= 1'b0;
      p_hold <= 1'b1;
    end else begin
      m1 <= {wpn, mosi, holdn, csn, sck};
      m2 <= m1;
      p_sck <= s_sck;
      p_csn <= s_csn;
      p_hold <= s_hold;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE;
      cnt <= '0;
      ocnt <= '0;
      sh <= '0;
      dsh <= '0;
      addr <= '0;
      bp <= '0;
      sr_new <= '0;
      is_rd <= 1'b0;
      got <= 1'b0;
      wel <= 1'b0;
      held <= 1'b0;
      live <= 1'b0;
      wr_stb <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
      wr_go <= 1'b0;
    end else begin
      wr_stb <= 1'b0;
      wr_go <= 1'b0;
      if (cs_rise) begin
        if (st == ST_WR && cnt == 3'd0 && got && wel) begin
          wr_go <= 1'b1;
          wel <= 1'b0;
        end
        if (st == ST_SRE && wel) begin
          bp <= sr_new;
          wel <= 1'b0;
        end
        st <= ST_IDLE;
        held <= 1'b0;
        live <= 1'b0;
      end else if (cs_fall) begin
        st <= ST_OPC;
        cnt <= '0;
        ocnt <= '0;
        got <= 1'b0;
        held <= 1'b0;
        live <= 1'b0;
      end else if (!s_csn) begin
        if (held) begin
          if (hold_rise && !s_sck) held <= 1'b0;
        end else if (hold_fall && !s_sck && st != ST_IDLE) begin
          held <= 1'b1;
        end else if (rise && in_st) begin
          sh <= byte_in[6:0];
          cnt <= cnt + 3'd1;
          case (st)
            ST_OPC: if (last) begin
              case (byte_in)
                8'h06: begin wel <= 1'b1; st <= ST_WAIT; end
                8'h04: begin wel <= 1'b0; st <= ST_WAIT; end
                8'h05: begin st <= ST_SRO; ocnt <= '0; end
                8'h01: st <= ST_SRI;
                8'h03: begin is_rd <= 1'b1; st <= wip ? ST_WAIT : ST_ADDR; end
                8'h02: begin is_rd <= 1'b0; st <= wip ? ST_WAIT : ST_ADDR; end
                default: st <= ST_WAIT;
              endcase
            end
            ST_ADDR: if (last) begin
              addr <= byte_in[AW-1:0];
              ocnt <= '0;
              st <= is_rd ? ST_RD : ST_WR;
            end
            ST_WR: if (last) begin
              if (wel && !prot(bp, addr)) begin
                wr_stb <= 1'b1;
                wr_addr <= addr;
                wr_data <= byte_in;
              end
              addr <= {addr[AW-1:PAGE_BITS], addr[PAGE_BITS-1:0] + 1'b1};
              got <= 1'b1;
            end
            ST_SRI: if (last) begin
              sr_new <= byte_in[3:2];
              st <= ST_SRE;
            end
            ST_SRE: st <= ST_WAIT;
            ST_SRO: if (last) begin
              st <= ST_WAIT;
              live <= 1'b0;
            end
            default: ;
          endcase
        end else if (fall && out_st) begin
          ocnt <= ocnt + 3'd1;
          if (ocnt == 3'd0) begin
            live <= 1'b1;
            if (st == ST_RD) begin
              dsh <= mem_rdata;
              addr <= addr + 1'b1;
            end else begin
              dsh <= {4'hF, bp, wel, wip};
            end
          end else begin
            dsh <= {dsh[6:0], 1'b0};
          end
        end
      end
      if (!s_wp) wel <= 1'b0;
    end
  end
endmodule

// File: rtl/spi_mem_slave_chk.sv
module spi_mem_slave_chk (
  input logic clk,
  input logic rst_n,
  input logic csn,
  input logic wip,
  input logic miso_oe,
  input logic wr_stb,
  input logic wr_go
);
  AST_OE_WHEN_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    miso_oe |-> !$past(csn, 2)); // R14
  AST_GO_ON_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_go |-> $past(csn, 3)); // R7
  AST_GO_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_go |=> !wr_go); // R7
  AST_STB_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> !wip); // R6
  AST_STB_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> !$past(csn, 3)); // R7
endmodule

bind spi_mem_slave spi_mem_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .csn(csn), .wip(wip),
  .miso_oe(miso_oe), .wr_stb(wr_stb), .wr_go(wr_go)
);

// File: tb/sim_spi_mem_slave.sv
module sim_spi_mem_slave;
  localparam int H = 6;
  localparam int BUSY = 2000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sck = 1'b0, csn = 1'b0, mosi = 1'b0, holdn = 1'b1, wpn = 1'b1;
  logic wip;
  logic [7:0] mem_rdata;
  logic miso, miso_oe, wr_stb, wr_go;
  logic [7:0] mem_addr, wr_addr, wr_data;

  logic [7:0] mem [256];
  logic [15:0] stq[$];
  logic [15:0] expq[$];
  int busy = 0, gos = 0, checks = 0, errors = 0;
  bit mode3 = 1'b0, csn_q = 1'b1;
  int hold_oe = 0;

  always #2 clk = ~clk;
  assign wip = (busy != 0);

  spi_mem_slave u0 (
    .clk(clk), .rst_n(rst_n), .sck(sck), .csn(csn), .mosi(mosi),
    .holdn(holdn), .wpn(wpn), .wip(wip), .mem_rdata(mem_rdata),
    .miso(miso), .miso_oe(miso_oe), .mem_addr(mem_addr),
    .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data), .wr_go(wr_go)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= 8'(i) ^ 8'h5A;
      busy <= 0;
    end else begin
      mem_rdata <= mem[mem_addr];
      if (csn_q && !csn) stq.delete();
      csn_q <= csn;
      if (wr_stb) stq.push_back({wr_addr, wr_data});
      if (wr_go) begin
        foreach (stq[k]) mem[stq[k][15:8]] <= stq[k][7:0];
        stq.delete();
        busy <= BUSY;
        gos <= gos + 1;
      end else if (busy != 0) busy <= busy - 1;
    end
  end

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", r, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && wr_stb) begin
      if (expq.size() == 0) chk(1'b0, "R7 unexpected stage", int'({wr_addr, wr_data}), 0);
      else begin
        logic [15:0] e;
        e = expq.pop_front();
        chk({wr_addr, wr_data} == e, "R7 staged byte", int'({wr_addr, wr_data}), int'(e));
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sel();
    csn = 1'b0;
    tick(2 * H);
  endtask

  task automatic desel();
    if (!mode3) sck = 1'b0;
    tick(H);
    csn = 1'b1;
    tick(2 * H);
  endtask

  task automatic xbits(input logic [7:0] tx, input int n, input int hold_at,
                       output logic [7:0] rx, output int oe_n);
    rx = '0;
    oe_n = 0;
    for (int i = 0; i < n; i++) begin
      sck = 1'b0;
      mosi = tx[7 - i];
      tick(H);
      if (i == hold_at) begin
        holdn = 1'b0;
        tick(H);
        sck = 1'b1; tick(H);
        sck = 1'b0; tick(H);
        hold_oe = int'(miso_oe);
        holdn = 1'b1;
        tick(H);
      end
      rx = {rx[6:0], miso};
      oe_n += int'(miso_oe);
      sck = 1'b1;
      tick(H);
    end
  endtask

  task automatic xbyte(input logic [7:0] tx, output logic [7:0] rx, output int oe_n);
    xbits(tx, 8, -1, rx, oe_n);
  endtask

  task automatic cmd(input logic [7:0] op);
    logic [7:0] r;
    int o;
    sel(); xbyte(op, r, o); desel();
  endtask

  task automatic rdsr(output logic [7:0] v, output int oe_v, output int oe_after);
    logic [7:0] r;
    int o;
    sel();
    xbyte(8'h05, r, o);
    xbyte(8'h00, v, oe_v);
    xbyte(8'h00, r, oe_after);
    desel();
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d[$]);
    logic [7:0] r;
    int o;
    sel();
    xbyte(8'h02, r, o);
    xbyte(a, r, o);
    foreach (d[k]) xbyte(d[k], r, o);
    desel();
  endtask

  task automatic rd(input logic [7:0] a, input int n, input int hold_at,
                    output logic [7:0] q[$], output int oe_tot);
    logic [7:0] r;
    int o;
    q.delete();
    oe_tot = 0;
    sel();
    xbyte(8'h03, r, o);
    xbyte(a, r, o);
    for (int k = 0; k < n; k++) begin
      xbits(8'h00, 8, (k == 0) ? hold_at : -1, r, o);
      q.push_back(r);
      oe_tot += o;
    end
    desel();
  endtask

  initial begin
    logic [7:0] v, r;
    logic [7:0] q[$];
    int o1, o2, g0;
    tick(5);
    chk(miso_oe == 1'b0 && wr_stb == 1'b0 && wr_go == 1'b0, "R14 reset outputs",
        int'({miso_oe, wr_stb, wr_go}), 0);
    rst_n = 1'b1;
    tick(4);

    // R2: selected through reset, no falling chip select seen yet
    xbyte(8'h05, r, o1);
    xbyte(8'h00, r, o2);
    chk(o2 == 0, "R2 no command before first select", o2, 0);
    desel();

    rdsr(v, o1, o2);
    chk(v == 8'hF0, "R3 status after reset", v, 8'hF0);
    chk(o1 == 8, "R14 oe during status", o1, 8);
    chk(o2 == 0, "R4 oe off after status byte", o2, 0);

    cmd(8'h06); rdsr(v, o1, o2);
    chk(v == 8'hF2, "R3 wel set", v, 8'hF2);
    cmd(8'h04); rdsr(v, o1, o2);
    chk(v == 8'hF0, "R3 wel cleared", v, 8'hF0);

    // R13
    wpn = 1'b0; tick(4);
    cmd(8'h06); rdsr(v, o1, o2);
    chk(v == 8'hF0, "R13 wel held clear by wpn", v, 8'hF0);
    wpn = 1'b1; tick(4);
    cmd(8'h06);
    wpn = 1'b0; tick(6); wpn = 1'b1; tick(4);
    rdsr(v, o1, o2);
    chk(v == 8'hF0, "R13 wpn pulse clears wel", v, 8'hF0);

    // R7 page write with wrap inside the page
    cmd(8'h06);
    g0 = gos;
    expq.push_back({8'h3E, 8'hA1});
    expq.push_back({8'h3F, 8'hB2});
    expq.push_back({8'h30, 8'hC3});
    wr(8'h3E, '{8'hA1, 8'hB2, 8'hC3});
    chk(gos == g0 + 1, "R7 commit pulse", gos - g0, 1);
    rdsr(v, o1, o2);
    chk(v == 8'hF1, "R7 busy set, wel cleared", v, 8'hF1);

    // R6 read and write refused while busy
    rd(8'h00, 1, -1, q, o1);
    chk(o1 == 0, "R6 read refused while busy", o1, 0);
    cmd(8'h06);
    g0 = gos;
    wr(8'h10, '{8'h77});
    chk(gos == g0, "R6 write refused while busy", gos - g0, 0);
    cmd(8'h04);
    tick(BUSY + 100);

    // R5 read stream and wrap
    rd(8'h3E, 3, -1, q, o1);
    chk(q[0] == 8'hA1 && q[1] == 8'hB2, "R5 written bytes", int'({q[0], q[1]}), 16'hA1B2);
    chk(q[2] == 8'h1A, "R5 increment", q[2], 8'h1A);
    chk(o1 == 24, "R14 oe during read data", o1, 24);
    rd(8'h30, 1, -1, q, o1);
    chk(q[0] == 8'hC3, "R7 page wrap byte", q[0], 8'hC3);
    rd(8'hFE, 3, -1, q, o1);
    chk(q[0] == 8'hA4 && q[1] == 8'hA5 && q[2] == 8'h5A, "R5 wrap FF to 00",
        int'({q[0], q[1], q[2]}), 24'hA4A55A);

    // R1 clock idling high
    mode3 = 1'b1; sck = 1'b1; tick(2 * H);
    rd(8'h3E, 2, -1, q, o1);
    chk(q[0] == 8'hA1 && q[1] == 8'hB2, "R1 idle-high clock read", int'({q[0], q[1]}), 16'hA1B2);
    rdsr(v, o1, o2);
    chk(v == 8'hF0, "R1 idle-high status", v, 8'hF0);
    mode3 = 1'b0; sck = 1'b0; tick(2 * H);

    // R11
    sel();
    xbyte(8'h55, r, o1);
    xbyte(8'h03, r, o1);
    xbyte(8'h3E, r, o1);
    xbyte(8'h00, r, o2);
    desel();
    chk(o2 == 0, "R11 read after bad code ignored", o2, 0);
    sel(); xbyte(8'hAA, r, o1); xbyte(8'h06, r, o1); desel();
    rdsr(v, o1, o2);
    chk(v == 8'hF0, "R11 wel unchanged after bad code", v, 8'hF0);

    // R8
    g0 = gos;
    wr(8'h20, '{8'h11});
    chk(gos == g0, "R8 no commit without wel", gos - g0, 0);
    cmd(8'h06);
    expq.push_back({8'h20, 8'h11});
    sel();
    xbyte(8'h02, r, o1); xbyte(8'h20, r, o1); xbyte(8'h11, r, o1);
    xbits(8'hF0, 4, -1, r, o1);
    desel();
    chk(gos == g0, "R8 no commit on partial byte", gos - g0, 0);
    rdsr(v, o1, o2);
    chk(v == 8'hF2, "R8 wel kept after abort", v, 8'hF2);
    rd(8'h20, 1, -1, q, o1);
    chk(q[0] == 8'h7A, "R8 memory unchanged", q[0], 8'h7A);

    // R9
    sel(); xbyte(8'h01, r, o1); xbyte(8'h08, r, o1); desel();
    rdsr(v, o1, o2);
    chk(v == 8'hF8, "R9 level 2 loaded", v, 8'hF8);
    cmd(8'h06);
    sel(); xbyte(8'h01, r, o1); xbyte(8'h00, r, o1); xbits(8'h00, 1, -1, r, o1); desel();
    rdsr(v, o1, o2);
    chk(v == 8'hFA, "R9 extra clock cancels load", v, 8'hFA);

    // R10
    g0 = gos;
    wr(8'h90, '{8'h33, 8'h44});
    chk(gos == g0 + 1 && expq.size() == 0, "R10 level 2 blocks 0x90", gos - g0, 1);
    tick(BUSY + 100);
    cmd(8'h06);
    expq.push_back({8'h7F, 8'h66});
    wr(8'h7F, '{8'h66});
    tick(BUSY + 100);
    rd(8'h7F, 2, -1, q, o1);
    chk(q[0] == 8'h66 && q[1] == 8'hDA, "R10 open below, protected kept",
        int'({q[0], q[1]}), 16'h66DA);
    cmd(8'h06);
    sel(); xbyte(8'h01, r, o1); xbyte(8'h04, r, o1); desel();
    rdsr(v, o1, o2);
    chk(v == 8'hF4, "R9 level 1 loaded", v, 8'hF4);
    cmd(8'h06);
    wr(8'hC5, '{8'h01});
    tick(BUSY + 100);
    cmd(8'h06);
    expq.push_back({8'hBF, 8'h12});
    wr(8'hBF, '{8'h12});
    tick(BUSY + 100);
    rd(8'hBF, 1, -1, q, o1);
    chk(q[0] == 8'h12, "R10 level 1 allows 0xBF", q[0], 8'h12);
    rd(8'hC5, 1, -1, q, o1);
    chk(q[0] == 8'h9F, "R10 level 1 blocks 0xC5", q[0], 8'h9F);

    // R12
    rd(8'h3E, 2, 3, q, o1);
    chk(hold_oe == 0, "R12 oe low in hold", hold_oe, 0);
    chk(q[0] == 8'hA1 && q[1] == 8'hB2, "R12 stream resumes", int'({q[0], q[1]}), 16'hA1B2);

    chk(expq.size() == 0, "R7 all expected stages seen", expq.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual %0d expected %0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule